// File: doc/BRIEF.md
# Bit-Addressable Output Port with Readback Selector

This block holds an 8-bit output register whose bits drive the keyboard row select lines, two cassette controls, the caps-lock indicator and the key-click tone. Software can update the register in either of two ways. A whole-byte store replaces all eight bits at once. A single-bit command changes just one bit and leaves the other seven as they are. In a single-bit command, the lowest data bit is the value to write and the next three data bits name the bit to change.

The block also selects what a processor read returns. Two low address bits choose one of four results: the keyboard column lines, the current value of an external page configuration register, this port register, or all ones. The data bus is split into an input byte, an output byte and an output-enable. The enable is high only while a read is in progress, and at that time the surrounding pad logic drives the bus.

Top module: `bitport_rdmux`

## Requirements
- R1: While `rst_n` is low the port register is 0x00, and it stays 0x00 after reset until the first write.
- R2: When `wr_par_i` is high at a rising clock edge, the port register takes the full value of `din_i`, which appears on `port_o` after that edge.
- R3: When `wr_bit_i` is high and `wr_par_i` is low at a rising edge, bit `din_i[3:1]` of the port register takes the value `din_i[0]`. The other seven bits are unchanged, and `din_i[7:4]` has no effect.
- R4: When both write strobes are high at the same edge, the full-byte store wins and the register takes `din_i`.
- R5: With neither write strobe high, the port register holds its value.
- R6: The register bits map to the named outputs as follows: bits 3..0 go to `row_sel_o`, bit 4 to `tape_motor_o`, bit 5 to `tape_wr_o`, bit 6 to `caps_led_o` and bit 7 to `click_o`.
- R7: During a read with `addr_i` = 00, `rd_data_o` equals `kbd_col_i` in the same cycle.
- R8: During a read with `addr_i` = 01, `rd_data_o` equals `page_cfg_i`.
- R9: During a read with `addr_i` = 10, `rd_data_o` equals the port register.
- R10: During a read with `addr_i` = 11, `rd_data_o` is 0xFF.
- R11: `rd_oe_o` follows `rd_stb_i`. While no read is in progress, `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_i | input | 8 | Write data sampled from the bus |
| addr_i | input | 2 | Read source select |
| wr_par_i | input | 1 | Full-byte write strobe |
| wr_bit_i | input | 1 | Single-bit write strobe |
| rd_stb_i | input | 1 | Read strobe |
| kbd_col_i | input | 8 | Keyboard column lines |
| page_cfg_i | input | 8 | Page configuration register value |
| port_o | output | 8 | Whole port register |
| row_sel_o | output | 4 | Keyboard row select |
| tape_motor_o | output | 1 | Cassette motor control |
| tape_wr_o | output | 1 | Cassette write data |
| caps_led_o | output | 1 | Caps-lock indicator |
| click_o | output | 1 | Key-click tone |
| rd_data_o | output | 8 | Read data to the bus |
| rd_oe_o | output | 1 | Bus drive enable |

## Verification
The register properties assume that the write strobes and `din_i` hold steady across each rising edge and are never unknown once reset is released. The readback properties assume that `addr_i` and the source inputs are steady while `rd_stb_i` is high. The stimulus changes every input only on the falling clock edge and keeps all inputs at known values from time zero. It also keeps reads and writes in separate cycles, so every sampled result comes from one stimulus.

// File: rtl/bitport_pkg.sv
package bitport_pkg;

    typedef enum logic [1:0] {
        SRC_KBD  = 2'b00,
        SRC_PAGE = 2'b01,
        SRC_PORT = 2'b10,
        SRC_ONES = 2'b11
    } rd_src_e;

endpackage

// File: rtl/bitport_reg.sv
module bitport_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_we,
    input  logic         bit_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] port_q
);
    localparam int unsigned IW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] port;
    } state_t;

    state_t        st_d, st_q;
    logic [IW-1:0] bit_idx;

    assign bit_idx = wdata[IW:1];

    always_comb begin
        st_d = st_q;
        if (par_we) begin
            st_d.port = wdata;
        end else if (bit_we) begin
            for (int i = 0; i < W; i++) begin
                if (bit_idx == IW'(i)) begin
                    st_d.port[i] = wdata[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_q = st_q.port;

    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        par_we |=> port_q == $past(wdata)); // R2

    AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we && bit_we) |=> port_q == $past(wdata)); // R4

    AST_BIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !par_we) |=> port_q[$past(bit_idx)] == $past(wdata[0])); // R3

    AST_BIT_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !par_we) |=>
            ((port_q ^ $past(port_q)) & ~(W'(1) << $past(bit_idx))) == '0); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_we && !bit_we) |=> $stable(port_q)); // R5

endmodule

// File: rtl/bitport_rdsel.sv
module bitport_rdsel
    import bitport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [1:0]   sel_i,
    input  logic         rd_stb_i,
    input  logic [W-1:0] kbd_i,
    input  logic [W-1:0] page_i,
    input  logic [W-1:0] port_i,
    output logic [W-1:0] rd_data_o,
    output logic         oe_o
);
    logic [W-1:0] mux_d;

    always_comb begin
        unique case (rd_src_e'(sel_i))
            SRC_KBD:  mux_d = kbd_i;
            SRC_PAGE: mux_d = page_i;
            SRC_PORT: mux_d = port_i;
            default:  mux_d = '1;
        endcase
    end

    assign rd_data_o = rd_stb_i ? mux_d : '0;
    assign oe_o      = rd_stb_i;

endmodule

// File: rtl/bitport_rdmux.sv
module bitport_rdmux
    import bitport_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din_i,
    input  logic [1:0]        addr_i,
    input  logic              wr_par_i,
    input  logic              wr_bit_i,
    input  logic              rd_stb_i,
    input  logic [DATA_W-1:0] kbd_col_i,
    input  logic [DATA_W-1:0] page_cfg_i,
    output logic [DATA_W-1:0] port_o,
    output logic [ROW_W-1:0]  row_sel_o,
    output logic              tape_motor_o,
    output logic              tape_wr_o,
    output logic              caps_led_o,
    output logic              click_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);
    localparam int unsigned MOTOR_B = ROW_W;
    localparam int unsigned TWR_B   = ROW_W + 1;
    localparam int unsigned CAPS_B  = ROW_W + 2;
    localparam int unsigned CLICK_B = ROW_W + 3;

    logic [DATA_W-1:0] port_q;

    bitport_reg #(.W(DATA_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .par_we (wr_par_i),
        .bit_we (wr_bit_i),
        .wdata  (din_i),
        .port_q (port_q)
    );

    bitport_rdsel #(.W(DATA_W)) u_rdsel (
        .sel_i     (addr_i),
        .rd_stb_i  (rd_stb_i),
        .kbd_i     (kbd_col_i),
        .page_i    (page_cfg_i),
        .port_i    (port_q),
        .rd_data_o (rd_data_o),
        .oe_o      (rd_oe_o)
    );

    assign port_o       = port_q;
    assign row_sel_o    = port_q[ROW_W-1:0];
    assign tape_motor_o = port_q[MOTOR_B];
    assign tape_wr_o    = port_q[TWR_B];
    assign caps_led_o   = port_q[CAPS_B];
    assign click_o      = port_q[CLICK_B];

    AST_RD_KBD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && addr_i == SRC_KBD) |-> rd_data_o == kbd_col_i); // R7

    AST_RD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && addr_i == SRC_PAGE) |-> rd_data_o == page_cfg_i); // R8

    AST_RD_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && addr_i == SRC_PORT) |-> rd_data_o == port_o); // R9

    AST_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && addr_i == SRC_ONES) |-> rd_data_o == '1); // R10

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |-> (!rd_oe_o && rd_data_o == '0)); // R11

endmodule

// File: tb/tb_bitport_rdmux.sv
module tb_bitport_rdmux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] addr = 2'b00;
    logic       wr_par = 1'b0;
    logic       wr_bit = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] kbd = 8'h00;
    logic [7:0] page = 8'h00;
    logic [7:0] port_o, rd_data;
    logic [3:0] row_sel;
    logic       motor, twr, caps, click, oe;

    int errors = 0;
    int checks = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    bitport_rdmux dut (
        .clk(clk), .rst_n(rst_n), .din_i(din), .addr_i(addr),
        .wr_par_i(wr_par), .wr_bit_i(wr_bit), .rd_stb_i(rd_stb),
        .kbd_col_i(kbd), .page_cfg_i(page), .port_o(port_o),
        .row_sel_o(row_sel), .tape_motor_o(motor), .tape_wr_o(twr),
        .caps_led_o(caps), .click_o(click), .rd_data_o(rd_data), .rd_oe_o(oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic par, input logic bitw, input logic [7:0] d);
        @(negedge clk);
        wr_par = par; wr_bit = bitw; din = d;
        @(negedge clk);
        wr_par = 1'b0; wr_bit = 1'b0; din = 8'h00;
        if (par) model = d;
        else if (bitw) model[d[3:1]] = d[0];
    endtask

    task automatic read(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #2;
        check(req, {24'h0, rd_data}, {24'h0, exp});
        check("R11 oe during read", {31'h0, oe}, 32'h1);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        #3;
        check("R1 reset value", {24'h0, port_o}, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {24'h0, port_o}, 32'h0);
    endtask

    task automatic t_parallel();
        write(1'b1, 1'b0, 8'hA5);
        check("R2 parallel A5", {24'h0, port_o}, {24'h0, model});
        write(1'b1, 1'b0, 8'h3C);
        check("R2 parallel 3C", {24'h0, port_o}, 32'h3C);
    endtask

    task automatic t_bitwrite();
        write(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 8; i++) begin
            write(1'b0, 1'b1, 8'(i << 1) | 8'h01);
            check("R3 bit set", {24'h0, port_o}, {24'h0, model});
        end
        check("R3 all set", {24'h0, port_o}, 32'hFF);
        for (int i = 7; i >= 0; i -= 2) begin
            write(1'b0, 1'b1, 8'(i << 1) | 8'hF0);
            check("R3 bit clear, upper bits ignored", {24'h0, port_o}, {24'h0, model});
        end
        check("R3 pattern", {24'h0, port_o}, 32'h55);
    endtask

    task automatic t_priority();
        write(1'b1, 1'b1, 8'h81);
        check("R4 parallel wins", {24'h0, port_o}, 32'h81);
    endtask

    task automatic t_hold();
        @(negedge clk);
        din = 8'hFF;
        repeat (3) @(negedge clk);
        check("R5 hold", {24'h0, port_o}, 32'h81);
        din = 8'h00;
    endtask

    task automatic t_fields();
        write(1'b1, 1'b0, 8'b1010_0110);
        check("R6 row select", {28'h0, row_sel}, 32'h6);
        check("R6 tape motor", {31'h0, motor}, 32'h0);
        check("R6 tape write", {31'h0, twr}, 32'h1);
        check("R6 caps led", {31'h0, caps}, 32'h0);
        check("R6 click", {31'h0, click}, 32'h1);
        write(1'b1, 1'b0, 8'b0101_1001);
        check("R6 motor/caps", {30'h0, motor, caps}, 32'h3);
        check("R6 row select 2", {28'h0, row_sel}, 32'h9);
    endtask

    task automatic t_readback();
        kbd = 8'h5E; page = 8'hC3;
        read(2'b00, 8'h5E, "R7 keyboard read");
        read(2'b01, 8'hC3, "R8 page read");
        read(2'b10, model, "R9 port read");
        read(2'b11, 8'hFF, "R10 ones read");
        kbd = 8'h01; page = 8'h80;
        read(2'b00, 8'h01, "R7 keyboard read 2");
        read(2'b01, 8'h80, "R8 page read 2");
        write(1'b0, 1'b1, 8'h0F);
        read(2'b10, model, "R9 port after bit write");
    endtask

    task automatic t_idle();
        @(negedge clk);
        addr = 2'b11; rd_stb = 1'b0;
        #2;
        check("R11 oe idle", {31'h0, oe}, 32'h0);
        check("R11 data idle", {24'h0, rd_data}, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_parallel();
                t_bitwrite();
                t_priority();
                t_hold();
                t_fields();
                t_readback();
                t_idle();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule